// File: doc/BRIEF.md
# Multi-Retirement Trace Group Packer

This block sits between a hart's retire stage and the ingress port of an instruction trace encoder. Each cycle the retire stage presents up to `W` instructions in program order. Every instruction comes with its address, a size code and a termination type code produced by an upstream classifier. The packer folds these instructions into `N` parallel trace groups. Each group describes one contiguous run of retired instructions by four fields: the start address, the number of 16-bit halfwords covered, the size code of the last instruction, and the termination type. A run closes at every instruction whose type code is non-zero, so each such instruction ends its own group.

At most one trap (exception or interrupt) can arrive per cycle. It is attached to the newest group in use, or it opens a fresh empty group. When it is reported, its cause and trap value appear on unreplicated outputs, together with the privilege level for the cycle.

When a cycle would need more groups than exist, the packer accepts only the oldest instructions that fit. It returns the accepted count in the same cycle so that the retire stage presents the rest again. A pending trap is withheld until it can be placed. All trace outputs are registered and therefore appear one clock after the inputs they describe.

Top module: `tg_packer`

## Requirements
- R1: Each used group's `grp_iaddr` equals the address of the oldest instruction in that group, and `grp_iretire` equals the sum of the halfword counts of its instructions. A size code of 0 means 1 halfword and a size code of 1 means 2 halfwords.
- R2: `grp_ilastsize` carries the size code of the newest instruction in the group, so that `grp_iaddr + 2*grp_iretire - 2*2^grp_ilastsize` is the address of that instruction.
- R3: A group closes at the first instruction whose type code is non-zero, and that code becomes the group's `grp_itype`. The next instruction starts the following group. A group left open at the end of the cycle has type 0.
- R4: Groups fill from index 0 upward, and group 0 holds the oldest instructions. Every unused group drives all of its fields as 0.
- R5: `acc_count` is combinational and equals the number of leading presented slots that fit into the `N` groups. Instructions beyond that prefix are not reported in the cycle.
- R6: An accepted trap is reported with type 1 for an exception or type 2 for an interrupt. If the newest used group is still open, the trap is placed on it and that group's start address is kept. Otherwise the trap opens the next group with `grp_iretire`=0 and `grp_iaddr`=`trap_addr`. No group above the trap group is used.
- R7: `trap_ack` is high exactly when `trap_valid` is high, all presented instructions are accepted and a group remains to carry the trap. Otherwise the trap is withheld from the outputs.
- R8: `out_cause` shows `trap_cause` in the cycle after an accepted trap and 0 otherwise. `out_tval` shows `trap_tval` only after an accepted exception and 0 otherwise.
- R9: `out_priv` is `priv_in` delayed by one clock.
- R10: All outputs except `acc_count` and `trap_ack` are registered one clock after their inputs. A synchronous active-low reset clears them to 0.
- R11: Slots at index `ret_count` and above have no effect on any output, whatever values they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ret_count | input | $clog2(W+1) | Number of valid slots, counted from slot 0 |
| slot_addr | input | W x AW | Address of each slot's instruction |
| slot_size | input | W x LSW | Size code (0: 1 halfword, 1: 2 halfwords) |
| slot_type | input | W x ITW | Termination type from the classifier, never 1 or 2 |
| trap_valid | input | 1 | A trap follows the newest presented instruction |
| trap_irq | input | 1 | 1: interrupt, 0: exception |
| trap_cause | input | CW | Trap cause |
| trap_tval | input | AW | Trap value |
| trap_addr | input | AW | Address reported when the trap opens an empty group |
| priv_in | input | PW | Privilege level of the presented instructions |
| acc_count | output | $clog2(W+1) | Slots accepted this cycle |
| trap_ack | output | 1 | Trap accepted this cycle |
| grp_iaddr | output | N x AW | Group start address |
| grp_iretire | output | N x IRW | Group halfword count |
| grp_ilastsize | output | N x LSW | Size code of the group's last instruction |
| grp_itype | output | N x ITW | Group termination type |
| out_cause | output | CW | Cause of the reported trap |
| out_tval | output | AW | Trap value of the reported exception |
| out_priv | output | PW | Registered privilege level |

## Verification
The hardest situation to reach from the ports is a trap that must be withheld. This happens when the presented batch already fills every group with type-terminated runs, or when instructions remain behind the accepted prefix. In the following cycle the same trap must then land on a partly filled or empty group. The stimulus keeps the density of non-zero type codes high, so many batches run out of groups. It also holds each raised trap pending until the design acknowledges it, so withheld traps recur with leftover instructions and with batches of zero instructions. A behavioural model checks every group field, the reconstructed last-instruction address, the accept count and the trap acknowledge on every clock.

// File: rtl/tgp_pkg.sv
// Package tgp_pkg
// Shared type codes for the trace group packer. The classifier never
// produces the two trap codes; only the packer inserts them.
package tgp_pkg;
    localparam int unsigned TG_NONE = 0;
    localparam int unsigned TG_EXC  = 1;
    localparam int unsigned TG_IRQ  = 2;
endpackage

// File: rtl/tgp_walker.sv
// Module tgp_walker
// Combinational packing of up to W retiring slots into N groups.
// Assumes: valid slots are contiguous from slot 0, ret_count <= W,
// slot_type is never 1 or 2, at most one trap per cycle.
module tgp_walker #(
    parameter int W    = 4,
    parameter int N    = 2,
    parameter int AW   = 32,
    parameter int LSW  = 1,
    parameter int ITW  = 4,
    parameter int IRW  = 4,
    parameter int CNTW = 3
) (
    input  logic [CNTW-1:0]         ret_count,
    input  logic [W-1:0][AW-1:0]    s_addr,
    input  logic [W-1:0][LSW-1:0]   s_size,
    input  logic [W-1:0][ITW-1:0]   s_type,
    input  logic                    trap_valid,
    input  logic                    trap_irq,
    input  logic [AW-1:0]           trap_addr,
    output logic [N-1:0][AW-1:0]    g_addr,
    output logic [N-1:0][IRW-1:0]   g_hw,
    output logic [N-1:0][LSW-1:0]   g_size,
    output logic [N-1:0][ITW-1:0]   g_type,
    output logic [CNTW-1:0]         acc,
    output logic                    tack
);
    import tgp_pkg::*;

    localparam int GIW  = $clog2(N + 1);
    localparam int GSEL = (N > 1) ? $clog2(N) : 1;

    logic [GIW-1:0] gi;
    logic           open_g;
    logic           full;
    logic [ITW-1:0] ttype;

    assign ttype = trap_irq ? ITW'(TG_IRQ) : ITW'(TG_EXC);

    // Walk slots oldest first, filling groups and then placing the trap.
    always_comb begin
        g_addr = '0;
        g_hw   = '0;
        g_size = '0;
        g_type = '0;
        acc    = '0;
        gi     = '0;
        open_g = 1'b0;
        full   = 1'b0;
        tack   = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (CNTW'(i) < ret_count && !full) begin
                if (gi == GIW'(N)) begin
                    full = 1'b1;
                end else begin
                    if (!open_g) begin
                        g_addr[gi[GSEL-1:0]] = s_addr[i];
                        open_g = 1'b1;
                    end
                    g_hw[gi[GSEL-1:0]]   = g_hw[gi[GSEL-1:0]] + (IRW'(1) << s_size[i]);
                    g_size[gi[GSEL-1:0]] = s_size[i];
                    acc = acc + CNTW'(1);
                    if (s_type[i] != '0) begin
                        g_type[gi[GSEL-1:0]] = s_type[i];
                        gi = gi + GIW'(1);
                        open_g = 1'b0;
                    end
                end
            end
        end
        if (trap_valid && acc == ret_count) begin
            if (open_g) begin
                g_type[gi[GSEL-1:0]] = ttype;
                tack = 1'b1;
            end else if (gi != GIW'(N)) begin
                g_addr[gi[GSEL-1:0]] = trap_addr;
                g_type[gi[GSEL-1:0]] = ttype;
                tack = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tgp_outreg.sv
// Module tgp_outreg
// Registers the packed groups and the unreplicated trap/privilege fields.
// Assumes: inputs are the walker results for the current cycle.
module tgp_outreg #(
    parameter int N   = 2,
    parameter int AW  = 32,
    parameter int LSW = 1,
    parameter int ITW = 4,
    parameter int IRW = 4,
    parameter int CW  = 6,
    parameter int PW  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0][AW-1:0]  g_addr,
    input  logic [N-1:0][IRW-1:0] g_hw,
    input  logic [N-1:0][LSW-1:0] g_size,
    input  logic [N-1:0][ITW-1:0] g_type,
    input  logic                  tack,
    input  logic                  trap_irq,
    input  logic [CW-1:0]         cause,
    input  logic [AW-1:0]         tval,
    input  logic [PW-1:0]         priv,
    output logic [N-1:0][AW-1:0]  q_addr,
    output logic [N-1:0][IRW-1:0] q_hw,
    output logic [N-1:0][LSW-1:0] q_size,
    output logic [N-1:0][ITW-1:0] q_type,
    output logic [CW-1:0]         q_cause,
    output logic [AW-1:0]         q_tval,
    output logic [PW-1:0]         q_priv
);
    for (genvar g = 0; g < N; g++) begin : g_grp
        // Hold one group's fields for the encoder.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_addr[g] <= '0;
                q_hw[g]   <= '0;
                q_size[g] <= '0;
                q_type[g] <= '0;
            end else begin
                q_addr[g] <= g_addr[g];
                q_hw[g]   <= g_hw[g];
                q_size[g] <= g_size[g];
                q_type[g] <= g_type[g];
            end
        end
    end

    // Hold the shared trap and privilege fields, zero when no trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cause <= '0;
            q_tval  <= '0;
            q_priv  <= '0;
        end else begin
            q_cause <= tack ? cause : '0;
            q_tval  <= (tack && !trap_irq) ? tval : '0;
            q_priv  <= priv;
        end
    end
endmodule

// File: rtl/tg_packer.sv
// Module tg_packer
// Top of the trace group packer: walker plus output registers.
// Assumes: the retire stage re-presents slots beyond acc_count and
// holds a trap until trap_ack.
module tg_packer #(
    parameter int W    = 4,
    parameter int N    = 2,
    parameter int AW   = 32,
    parameter int LSW  = 1,
    parameter int ITW  = 4,
    parameter int CW   = 6,
    parameter int PW   = 3,
    localparam int CNTW  = $clog2(W + 1),
    localparam int MAXHW = 1 << ((1 << LSW) - 1),
    localparam int IRW   = $clog2(W * MAXHW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNTW-1:0]       ret_count,
    input  logic [W-1:0][AW-1:0]  slot_addr,
    input  logic [W-1:0][LSW-1:0] slot_size,
    input  logic [W-1:0][ITW-1:0] slot_type,
    input  logic                  trap_valid,
    input  logic                  trap_irq,
    input  logic [CW-1:0]         trap_cause,
    input  logic [AW-1:0]         trap_tval,
    input  logic [AW-1:0]         trap_addr,
    input  logic [PW-1:0]         priv_in,
    output logic [CNTW-1:0]       acc_count,
    output logic                  trap_ack,
    output logic [N-1:0][AW-1:0]  grp_iaddr,
    output logic [N-1:0][IRW-1:0] grp_iretire,
    output logic [N-1:0][LSW-1:0] grp_ilastsize,
    output logic [N-1:0][ITW-1:0] grp_itype,
    output logic [CW-1:0]         out_cause,
    output logic [AW-1:0]         out_tval,
    output logic [PW-1:0]         out_priv
);
    logic [N-1:0][AW-1:0]  w_addr;
    logic [N-1:0][IRW-1:0] w_hw;
    logic [N-1:0][LSW-1:0] w_size;
    logic [N-1:0][ITW-1:0] w_type;

    tgp_walker #(.W(W), .N(N), .AW(AW), .LSW(LSW), .ITW(ITW), .IRW(IRW), .CNTW(CNTW)) u_walk (
        .ret_count (ret_count),
        .s_addr    (slot_addr),
        .s_size    (slot_size),
        .s_type    (slot_type),
        .trap_valid(trap_valid),
        .trap_irq  (trap_irq),
        .trap_addr (trap_addr),
        .g_addr    (w_addr),
        .g_hw      (w_hw),
        .g_size    (w_size),
        .g_type    (w_type),
        .acc       (acc_count),
        .tack      (trap_ack)
    );

    tgp_outreg #(.N(N), .AW(AW), .LSW(LSW), .ITW(ITW), .IRW(IRW), .CW(CW), .PW(PW)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .g_addr  (w_addr),
        .g_hw    (w_hw),
        .g_size  (w_size),
        .g_type  (w_type),
        .tack    (trap_ack),
        .trap_irq(trap_irq),
        .cause   (trap_cause),
        .tval    (trap_tval),
        .priv    (priv_in),
        .q_addr  (grp_iaddr),
        .q_hw    (grp_iretire),
        .q_size  (grp_ilastsize),
        .q_type  (grp_itype),
        .q_cause (out_cause),
        .q_tval  (out_tval),
        .q_priv  (out_priv)
    );

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_count <= ret_count); // R5
    AST_TRAP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ack |-> (trap_valid && acc_count == ret_count)); // R7
    AST_CAUSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cause != '0) |-> $past(trap_ack)); // R8
    AST_PRIV_DLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_priv == $past(priv_in))); // R9

    for (genvar g = 0; g < N - 1; g++) begin : g_chk
        AST_TRAP_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_itype[g] == ITW'(1) || grp_itype[g] == ITW'(2))
            |-> (grp_iretire[g+1] == '0 && grp_itype[g+1] == '0)); // R6
        AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_iretire[g+1] != '0 || grp_itype[g+1] != '0)
            |-> (grp_iretire[g] != '0 || grp_itype[g] != '0)); // R4
    end
endmodule

// File: tb/tg_packer_tb.sv
`timescale 1ns/1ps
module tg_packer_tb;
    localparam int W = 4, N = 2, AW = 32, LSW = 1, ITW = 4, CW = 6, PW = 3;
    localparam int CNTW = 3, IRW = 4;

    typedef struct { logic [31:0] a; int sz; int ty; } ins_t;

    logic clk = 0, rst_n = 0;
    logic [CNTW-1:0] ret_count = '0;
    logic [W-1:0][AW-1:0] slot_addr = '0;
    logic [W-1:0][LSW-1:0] slot_size = '0;
    logic [W-1:0][ITW-1:0] slot_type = '0;
    logic trap_valid = 0, trap_irq = 0;
    logic [CW-1:0] trap_cause = '0;
    logic [AW-1:0] trap_tval = '0, trap_addr = '0;
    logic [PW-1:0] priv_in = '0;
    logic [CNTW-1:0] acc_count;
    logic trap_ack;
    logic [N-1:0][AW-1:0] grp_iaddr;
    logic [N-1:0][IRW-1:0] grp_iretire;
    logic [N-1:0][LSW-1:0] grp_ilastsize;
    logic [N-1:0][ITW-1:0] grp_itype;
    logic [CW-1:0] out_cause;
    logic [AW-1:0] out_tval;
    logic [PW-1:0] out_priv;

    tg_packer u_dut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;
    ins_t q[$];
    logic [31:0] pc = 32'h1000;

    logic [31:0] e_addr[N], e_last[N];
    int e_hw[N], e_ls[N], e_ty[N];
    logic [CW-1:0] e_cause; logic [AW-1:0] e_tval; logic [PW-1:0] e_priv;
    int m_acc; bit m_tack;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic gen_one();
        ins_t x;
        x.a = pc; x.sz = $urandom % 2;
        x.ty = ($urandom % 5 < 2) ? 3 + ($urandom % 13) : 0;
        q.push_back(x);
        if (x.ty != 0 && $urandom % 2 == 1) pc = {$urandom, 1'b0};
        else pc = pc + 32'(2 * (1 << x.sz));
    endtask

    // Behavioural reference: split presented slots into groups.
    task automatic model(input int cnt);
        int g; bit op;
        g = 0; op = 0; m_acc = 0; m_tack = 0;
        for (int k = 0; k < N; k++) begin e_addr[k] = 0; e_last[k] = 0; e_hw[k] = 0; e_ls[k] = 0; e_ty[k] = 0; end
        for (int k = 0; k < cnt; k++) begin
            if (g == N) break;
            if (!op) begin e_addr[g] = q[k].a; op = 1; end
            e_hw[g] += (1 << q[k].sz); e_ls[g] = q[k].sz; e_last[g] = q[k].a; m_acc++;
            if (q[k].ty != 0) begin e_ty[g] = q[k].ty; g++; op = 0; end
        end
        if (trap_valid && m_acc == cnt) begin
            if (op) begin e_ty[g] = trap_irq ? 2 : 1; m_tack = 1; end
            else if (g < N) begin e_addr[g] = trap_addr; e_ty[g] = trap_irq ? 2 : 1; m_tack = 1; end
        end
        e_cause = m_tack ? trap_cause : '0;
        e_tval = (m_tack && !trap_irq) ? trap_tval : '0;
        e_priv = priv_in;
    endtask

    task automatic compare_out();
        for (int g = 0; g < N; g++) begin
            chk(grp_iaddr[g] == e_addr[g], "R1/R4/R6 iaddr", 64'(grp_iaddr[g]), 64'(e_addr[g]));
            chk(int'(grp_iretire[g]) == e_hw[g], "R1/R6 iretire", 64'(grp_iretire[g]), 64'(e_hw[g]));
            chk(int'(grp_ilastsize[g]) == e_ls[g], "R2 ilastsize", 64'(grp_ilastsize[g]), 64'(e_ls[g]));
            chk(int'(grp_itype[g]) == e_ty[g], "R3/R6 itype", 64'(grp_itype[g]), 64'(e_ty[g]));
            if (e_hw[g] != 0) begin
                logic [31:0] la;
                la = grp_iaddr[g] + 32'(2 * int'(grp_iretire[g])) - 32'(2 * (1 << grp_ilastsize[g]));
                chk(la == e_last[g], "R2 last address", 64'(la), 64'(e_last[g]));
            end
        end
        chk(out_cause == e_cause, "R8 cause", 64'(out_cause), 64'(e_cause));
        chk(out_tval == e_tval, "R8 tval", 64'(out_tval), 64'(e_tval));
        chk(out_priv == e_priv, "R9 priv", 64'(out_priv), 64'(e_priv));
    endtask

    task automatic drive_rand_slots();
        for (int i = 0; i < W; i++) begin   // R11: junk everywhere, valid slots overwritten
            slot_addr[i] = $urandom; slot_size[i] = LSW'($urandom); slot_type[i] = ITW'($urandom);
        end
    endtask

    initial begin
        int cnt; bit tpend; tpend = 0;
        for (int i = 0; i < 3 * W; i++) gen_one();
        // R10 reset state
        repeat (3) begin
            @(negedge clk);
            drive_rand_slots(); ret_count = CNTW'(W); trap_valid = 1; priv_in = 3'd3;
            trap_cause = 6'h11;
        end
        @(negedge clk);
        for (int g = 0; g < N; g++) begin
            chk(grp_iaddr[g] == 0 && grp_iretire[g] == 0, "R10 reset groups", 64'(grp_iaddr[g]), 64'h0);
            chk(grp_itype[g] == 0 && grp_ilastsize[g] == 0, "R10 reset type", 64'(grp_itype[g]), 64'h0);
        end
        chk(out_cause == 0 && out_tval == 0 && out_priv == 0, "R10 reset trap", 64'(out_cause), 64'h0);
        trap_valid = 0;
        for (int c = 0; c < 6000; c++) begin
            if (c > 0) begin
                @(negedge clk);
                compare_out();
            end
            rst_n = 1;
            while (q.size() < 2 * W) gen_one();
            if (!tpend && $urandom % 6 == 0) begin
                tpend = 1; trap_irq = $urandom % 2;
                trap_cause = CW'(1 + $urandom % 63); trap_tval = $urandom | 32'h1;
                trap_addr = {$urandom, 1'b0};
            end
            trap_valid = tpend;
            cnt = $urandom % (W + 1);
            ret_count = CNTW'(cnt);
            drive_rand_slots();
            for (int i = 0; i < cnt; i++) begin
                slot_addr[i] = q[i].a; slot_size[i] = LSW'(q[i].sz); slot_type[i] = ITW'(q[i].ty);
            end
            priv_in = PW'($urandom);
            #1;
            model(cnt);
            chk(int'(acc_count) == m_acc, "R5 acc_count", 64'(acc_count), 64'(m_acc));
            chk(trap_ack == m_tack, "R7 trap_ack", 64'(trap_ack), 64'(m_tack));
            for (int i = 0; i < m_acc; i++) void'(q.pop_front());
            if (m_tack) tpend = 0;
        end
        @(negedge clk);
        compare_out();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule